// File: doc/BRIEF.md
# I2C Master Command Queue Front End

This block sits between a host register port and the byte engine of an I2C master. The host writes command words into a transmit queue. Each word either carries a byte to send or asks the engine to clock in one byte from the bus. The byte engine takes commands from the head of that queue. It pushes each received byte into a receive queue, and the host drains that queue by reading the same data register it writes commands to.

The host can read both queue levels, the configured depths and its own thresholds. Two level-driven flags follow the thresholds: transmit-low, which tells the host there is room to refill, and receive-ready, which tells it there are bytes to collect. Three one-cycle pulses report dropped or empty accesses. Clearing the enable bit empties both queues at once, which is how a transfer is abandoned. Bus signalling, clock generation and interrupt masking belong to other blocks.

Top module: `i2c_cmdq_front`

## Requirements
- R1: After reset the enable bit is 0, both levels are 0, transmit-low is 1, receive-ready is 0, no command is offered to the engine, and all three pulses are 0.
- R2: While enabled, a host write to register index 1 with bit 8 clear queues bits 7:0 as a send command. The engine sees it as the 9-bit value {0, byte}, and commands leave in the order they were written.
- R3: A write to index 1 with bit 8 set queues a read request. The engine sees it as 0x100, whatever bits 7:0 held.
- R4: A host read of index 1 returns the oldest received byte in bits 7:0 and removes it from the queue. If the receive queue is empty, the read returns 0, the level stays 0, and `rx_under_pulse` is 1 for the cycle after the read.
- R5: Index 4 reads the transmit level and index 5 reads the receive level. A push and a pop on the same queue in the same cycle leave its level unchanged.
- R6: Index 6 reads transmit depth minus one in bits 23:16 and receive depth minus one in bits 15:8. All other bits of index 6 read 0.
- R7: `tx_low_flag` is 1 exactly when the transmit level is at or below the threshold at index 2. A written threshold larger than depth minus one is stored as depth minus one, so that value makes the flag 1 whenever the queue is not full.
- R8: `rx_ready_flag` is 1 exactly when the receive level is above the threshold at index 3. A threshold of 0 raises the flag as soon as one byte is present.
- R9: A host push into a full transmit queue is dropped, even if the engine pops in the same cycle. `tx_over_pulse` is then 1 for the following cycle only.
- R10: An engine push into a full receive queue is dropped. `rx_over_pulse` is then 1 for the following cycle.
- R11: Writing 0 to bit 0 of index 0 empties both queues by the next cycle. While the enable bit is 0, host pushes and engine pushes are dropped and raise no pulse.
- R12: `eng_cmd_valid` is 1 exactly when the transmit queue holds a command, and `eng_cmd` is the oldest command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops when it targets index 1 |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current index, valid in the same cycle |
| eng_cmd_valid | output | 1 | Transmit queue holds a command |
| eng_cmd | output | 9 | Head command; bit 8 marks a read request |
| eng_cmd_pop | input | 1 | Engine takes the head command |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| tx_low_flag | output | 1 | Transmit level at or below its threshold |
| rx_ready_flag | output | 1 | Receive level above its threshold |
| tx_over_pulse | output | 1 | A host push was dropped on a full queue |
| rx_under_pulse | output | 1 | A host pop found the receive queue empty |
| rx_over_pulse | output | 1 | An engine push was dropped on a full queue |

## Verification
On each queue, a host access and an engine access can land in the same cycle. The bench drives both strobes from one negative edge: a host command write with an engine pop, and a host data read with an engine byte push. It repeats each pairing on a partly filled queue, on a full transmit queue and on an empty receive queue. The checks then read the level at the ports, compare the popped command and the returned byte against the scoreboard, and confirm that only the dropped or empty side raises its pulse.

// File: rtl/i2c_cmdq_pkg.sv
package i2c_cmdq_pkg;

   localparam int REG_AW = 3;
   localparam int CMD_W  = 9;
   localparam int BYTE_W = 8;

   // register indexes; the data index is shared by pushes and pops
   localparam logic [REG_AW-1:0] RA_ENABLE = 3'd0;
   localparam logic [REG_AW-1:0] RA_DATA   = 3'd1;
   localparam logic [REG_AW-1:0] RA_TXTHR  = 3'd2;
   localparam logic [REG_AW-1:0] RA_RXTHR  = 3'd3;
   localparam logic [REG_AW-1:0] RA_TXLVL  = 3'd4;
   localparam logic [REG_AW-1:0] RA_RXLVL  = 3'd5;
   localparam logic [REG_AW-1:0] RA_PARAM  = 3'd6;

   // a read request carries no payload
   localparam logic [CMD_W-1:0] CMD_READ = 9'h100;

endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [LW-1:0] level,
   output logic          empty,
   output logic          full
);

   initial begin
      if (DEPTH < 2 || DEPTH > 256) $fatal(1, "cmdq_fifo: DEPTH must lie in 2..256");
      if (W < 1) $fatal(1, "cmdq_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          push_ok, pop_ok;

   assign empty   = (level == '0);
   assign full    = (level == LW'(DEPTH));
   // full is judged before any same-cycle pop, keeping it off the pop path
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + AW'(1);
         assign rd_nxt = rd_ptr + AW'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + LW'(1);
            2'b01:   level <= level - LW'(1);
            default: level <= level;
         endcase
      end
   end

   // R5: the level never exceeds the depth
   a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) <= DEPTH);

   // R9 and R10: a push on a full queue with no pop leaves it full
   a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> full);

   // R5: a simultaneous push and pop on a partly filled queue keep the level
   a_r5_level_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !full && !empty && !flush) |=> $stable(level));

endmodule

// File: rtl/cmdq_regs.sv
module cmdq_regs
   import i2c_cmdq_pkg::*;
#(
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8,
   localparam int TT_W    = $clog2(TX_DEPTH),
   localparam int RT_W    = $clog2(RX_DEPTH),
   localparam int TXL_W   = $clog2(TX_DEPTH + 1),
   localparam int RXL_W   = $clog2(RX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic [TXL_W-1:0]  tx_level,
   input  logic [RXL_W-1:0]  rx_level,
   input  logic [BYTE_W-1:0] rx_head,
   input  logic              rx_empty,
   output logic              enable,
   output logic [TT_W-1:0]   tx_thr,
   output logic [RT_W-1:0]   rx_thr,
   output logic [31:0]       reg_rdata
);

   localparam logic [31:0] PARAM_WORD =
      {8'h00, 8'(TX_DEPTH - 1), 8'(RX_DEPTH - 1), 8'h00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= 1'b0;
         tx_thr <= '0;
         rx_thr <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            RA_ENABLE: enable <= reg_wdata[0];
            RA_TXTHR:  tx_thr <= (reg_wdata > 32'(TX_DEPTH - 1)) ?
                                 TT_W'(TX_DEPTH - 1) : reg_wdata[TT_W-1:0];
            RA_RXTHR:  rx_thr <= (reg_wdata > 32'(RX_DEPTH - 1)) ?
                                 RT_W'(RX_DEPTH - 1) : reg_wdata[RT_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (reg_addr)
         RA_ENABLE: reg_rdata = {31'd0, enable};
         RA_DATA:   reg_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
         RA_TXTHR:  reg_rdata = 32'(tx_thr);
         RA_RXTHR:  reg_rdata = 32'(rx_thr);
         RA_TXLVL:  reg_rdata = 32'(tx_level);
         RA_RXLVL:  reg_rdata = 32'(rx_level);
         RA_PARAM:  reg_rdata = PARAM_WORD;
         default:   reg_rdata = 32'd0;
      endcase
   end

   // R7: an oversized threshold write is stored as depth minus one
   a_r7_thr_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == RA_TXTHR && reg_wdata >= 32'(TX_DEPTH - 1))
      |=> (tx_thr == TT_W'(TX_DEPTH - 1)));

endmodule

// File: rtl/i2c_cmdq_front.sv
module i2c_cmdq_front
   import i2c_cmdq_pkg::*;
#(
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        eng_cmd_valid,
   output logic [8:0]  eng_cmd,
   input  logic        eng_cmd_pop,
   input  logic        eng_rx_push,
   input  logic [7:0]  eng_rx_byte,
   output logic        tx_low_flag,
   output logic        rx_ready_flag,
   output logic        tx_over_pulse,
   output logic        rx_under_pulse,
   output logic        rx_over_pulse
);

   localparam int TT_W  = $clog2(TX_DEPTH);
   localparam int RT_W  = $clog2(RX_DEPTH);
   localparam int TXL_W = $clog2(TX_DEPTH + 1);
   localparam int RXL_W = $clog2(RX_DEPTH + 1);

   logic              enable;
   logic [TT_W-1:0]   tx_thr;
   logic [RT_W-1:0]   rx_thr;
   logic [TXL_W-1:0]  tx_level;
   logic [RXL_W-1:0]  rx_level;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic [BYTE_W-1:0] rx_head;
   logic [CMD_W-1:0]  tx_din;
   logic              host_push, host_pop, eng_push_en, eng_pop_en;

   assign host_push   = reg_wr && (reg_addr == RA_DATA) && enable;
   assign host_pop    = reg_rd && (reg_addr == RA_DATA) && enable;
   assign eng_push_en = eng_rx_push && enable;
   assign eng_pop_en  = eng_cmd_pop && enable;
   assign tx_din      = reg_wdata[8] ? CMD_READ : {1'b0, reg_wdata[7:0]};

   cmdq_regs #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .tx_level(tx_level), .rx_level(rx_level),
      .rx_head(rx_head), .rx_empty(rx_empty), .enable(enable),
      .tx_thr(tx_thr), .rx_thr(rx_thr), .reg_rdata(reg_rdata)
   );

   cmdq_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(!enable), .push(host_push),
      .din(tx_din), .pop(eng_pop_en), .dout(eng_cmd), .level(tx_level),
      .empty(tx_empty), .full(tx_full)
   );

   cmdq_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(!enable), .push(eng_push_en),
      .din(eng_rx_byte), .pop(host_pop), .dout(rx_head), .level(rx_level),
      .empty(rx_empty), .full(rx_full)
   );

   assign eng_cmd_valid = !tx_empty;
   assign tx_low_flag   = (32'(tx_level) <= 32'(tx_thr));
   assign rx_ready_flag = (32'(rx_level) >  32'(rx_thr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_over_pulse  <= 1'b0;
         rx_under_pulse <= 1'b0;
         rx_over_pulse  <= 1'b0;
      end else begin
         tx_over_pulse  <= host_push && tx_full;
         rx_under_pulse <= host_pop && rx_empty;
         rx_over_pulse  <= eng_push_en && rx_full;
      end
   end

   // R3: a read request never carries payload bits to the engine
   a_r3_read_cmd_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_cmd_valid && eng_cmd[8]) |-> (eng_cmd[7:0] == 8'h00));

   // R4: a data read on an empty receive queue is reported next cycle
   a_r4_under_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == RA_DATA && enable && rx_level == '0)
      |=> rx_under_pulse);

   // R10: an engine push on a full receive queue is reported next cycle
   a_r10_over_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_push && enable && rx_level == RXL_W'(RX_DEPTH)) |=> rx_over_pulse);

   // R11: a cleared enable bit leaves both queues empty after the edge
   a_r11_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (tx_level == '0 && rx_level == '0));

endmodule

// File: tb/i2c_cmdq_front_tb.sv
`timescale 1ns/100ps
module i2c_cmdq_front_tb;

   localparam int TXD = 8;
   localparam int RXD = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n, reg_wr, reg_rd, eng_cmd_pop, eng_rx_push;
   logic [2:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic [7:0]  eng_rx_byte;
   logic        eng_cmd_valid, tx_low_flag, rx_ready_flag;
   logic        tx_over_pulse, rx_under_pulse, rx_over_pulse;
   logic [8:0]  eng_cmd;

   i2c_cmdq_front #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd),
      .eng_cmd_pop(eng_cmd_pop), .eng_rx_push(eng_rx_push),
      .eng_rx_byte(eng_rx_byte), .tx_low_flag(tx_low_flag),
      .rx_ready_flag(rx_ready_flag), .tx_over_pulse(tx_over_pulse),
      .rx_under_pulse(rx_under_pulse), .rx_over_pulse(rx_over_pulse)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;
   bit en_m = 0;
   int exp_tx = 0;
   int exp_rx = 0;
   logic [8:0] txq[$];
   logic [7:0] rxq[$];

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] to_cmd(logic [31:0] d);
      return d[8] ? 9'h100 : {1'b0, d[7:0]};
   endfunction

   // scoreboard monitor: each engine pop is compared with the oldest expected command
   always @(negedge clk) begin
      #1;
      if (rst_n && eng_cmd_pop) begin
         check("R12 valid", {31'd0, eng_cmd_valid}, {31'd0, (txq.size() != 0)});
         if (eng_cmd_valid && txq.size() != 0) begin
            logic [8:0] e;
            e = txq.pop_front();
            check("R2/R3 cmd order", {23'd0, eng_cmd}, {23'd0, e});
         end
      end
   end

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_rd = 1; reg_addr = a;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 0;
   endtask

   task automatic lvl_check(string tag);
      logic [31:0] v;
      rd(3'd4, v); check({tag, " R5 tx level"}, v, exp_tx);
      rd(3'd5, v); check({tag, " R5 rx level"}, v, exp_rx);
   endtask

   task automatic host_push(logic [31:0] d);
      bit full_b;
      full_b = en_m && (exp_tx == TXD);
      wr(3'd1, d);
      if (en_m && !full_b) begin txq.push_back(to_cmd(d)); exp_tx++; end
      check("R9 tx_over_pulse", {31'd0, tx_over_pulse}, {31'd0, full_b});
   endtask

   task automatic eng_pop();
      @(negedge clk);
      eng_cmd_pop = 1;
      @(negedge clk);
      eng_cmd_pop = 0;
      if (exp_tx > 0) exp_tx--;
   endtask

   task automatic push_and_pop(logic [31:0] d);
      bit full_b, popped;
      full_b = en_m && (exp_tx == TXD);
      popped = exp_tx > 0;
      @(negedge clk);
      reg_wr = 1; reg_addr = 3'd1; reg_wdata = d; eng_cmd_pop = 1;
      @(negedge clk);
      reg_wr = 0; eng_cmd_pop = 0;
      if (popped) exp_tx--;
      if (en_m && !full_b) begin txq.push_back(to_cmd(d)); exp_tx++; end
      check("R9 same-cycle tx_over_pulse", {31'd0, tx_over_pulse}, {31'd0, full_b});
   endtask

   task automatic eng_push(logic [7:0] b);
      bit full_b;
      full_b = en_m && (exp_rx == RXD);
      @(negedge clk);
      eng_rx_push = 1; eng_rx_byte = b;
      @(negedge clk);
      eng_rx_push = 0;
      if (en_m && !full_b) begin rxq.push_back(b); exp_rx++; end
      check("R10 rx_over_pulse", {31'd0, rx_over_pulse}, {31'd0, full_b});
   endtask

   task automatic host_pop(logic do_push, logic [7:0] b);
      logic [31:0] v, e;
      bit empty_b, full_b;
      empty_b = (exp_rx == 0);
      full_b = (exp_rx == RXD);
      e = empty_b ? 32'd0 : {24'd0, rxq[0]};
      @(negedge clk);
      reg_rd = 1; reg_addr = 3'd1;
      eng_rx_push = do_push; eng_rx_byte = b;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 0; eng_rx_push = 0;
      check("R4 read byte", v, e);
      if (!empty_b) begin void'(rxq.pop_front()); exp_rx--; end
      if (do_push && !full_b) begin rxq.push_back(b); exp_rx++; end
      check("R4 rx_under_pulse", {31'd0, rx_under_pulse}, {31'd0, empty_b});
   endtask

   initial begin
      logic [31:0] v;
      rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
      eng_cmd_pop = 0; eng_rx_push = 0; eng_rx_byte = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check("R1 tx_low_flag", {31'd0, tx_low_flag}, 32'd1);
      check("R1 rx_ready_flag", {31'd0, rx_ready_flag}, 32'd0);
      check("R1 eng_cmd_valid", {31'd0, eng_cmd_valid}, 32'd0);
      check("R1 pulses", {29'd0, tx_over_pulse, rx_under_pulse, rx_over_pulse}, 32'd0);
      rd(3'd0, v); check("R1 enable", v, 32'd0);
      lvl_check("R1");

      // R6 depth word
      rd(3'd6, v); check("R6 param", v, {8'h00, 8'(TXD - 1), 8'(RXD - 1), 8'h00});

      // R11 pushes dropped while disabled
      host_push(32'h55);
      lvl_check("R11 disabled");

      wr(3'd0, 32'd1); en_m = 1;

      // R2 and R3 send and read commands
      host_push(32'h011);
      host_push(32'h022);
      host_push(32'h1AB);
      lvl_check("R2");
      check("R7 flag thr0 lvl3", {31'd0, tx_low_flag}, 32'd0);
      wr(3'd2, 32'd2);
      @(negedge clk); check("R7 flag thr2 lvl3", {31'd0, tx_low_flag}, 32'd0);
      wr(3'd2, 32'd3);
      @(negedge clk); check("R7 flag thr3 lvl3", {31'd0, tx_low_flag}, 32'd1);
      wr(3'd2, 32'd100);
      rd(3'd2, v); check("R7 thr clamp", v, TXD - 1);
      repeat (3) eng_pop();
      lvl_check("R12 drained");
      check("R12 valid empty", {31'd0, eng_cmd_valid}, 32'd0);

      // R9 fill and overflow
      for (int i = 0; i < TXD; i++) begin
         host_push(32'h30 + i);
         if (i == TXD - 2) check("R7 flag not full", {31'd0, tx_low_flag}, 32'd1);
      end
      check("R7 flag full", {31'd0, tx_low_flag}, 32'd0);
      host_push(32'h99);
      @(negedge clk);
      check("R9 pulse one cycle", {31'd0, tx_over_pulse}, 32'd0);
      lvl_check("R9 full");

      // same-cycle host push and engine pop
      push_and_pop(32'h77);
      push_and_pop(32'h1FF);
      lvl_check("R5 same-cycle tx");
      while (exp_tx > 0) eng_pop();
      lvl_check("R2 drained");

      // R8 receive flag and R10 overflow
      wr(3'd3, 32'd0);
      eng_push(8'hA5);
      check("R8 flag thr0", {31'd0, rx_ready_flag}, 32'd1);
      wr(3'd3, 32'd1);
      @(negedge clk); check("R8 flag thr1 lvl1", {31'd0, rx_ready_flag}, 32'd0);
      for (int i = 1; i < RXD; i++) eng_push(8'(8'h60 + i));
      check("R8 flag full", {31'd0, rx_ready_flag}, 32'd1);
      eng_push(8'hEE);
      lvl_check("R10 full");

      // R4 drain in order, then underflow
      while (exp_rx > 0) host_pop(1'b0, 8'h00);
      host_pop(1'b0, 8'h00);
      lvl_check("R4 empty");

      // same-cycle host pop and engine push
      eng_push(8'h3C);
      host_pop(1'b1, 8'h4D);
      lvl_check("R5 same-cycle rx");
      host_pop(1'b1, 8'h5E);
      host_pop(1'b0, 8'h00);
      host_pop(1'b1, 8'h6F);
      lvl_check("R4 under with push");
      host_pop(1'b0, 8'h00);

      // R11 flush
      host_push(32'h0A);
      host_push(32'h0B);
      eng_push(8'h1A);
      eng_push(8'h1B);
      lvl_check("R11 before flush");
      wr(3'd0, 32'd0); en_m = 0;
      txq.delete(); rxq.delete(); exp_tx = 0; exp_rx = 0;
      lvl_check("R11 flushed");
      eng_push(8'h12);
      host_push(32'h13);
      lvl_check("R11 disabled push");
      check("R11 valid", {31'd0, eng_cmd_valid}, 32'd0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule